// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tags

This block takes an asynchronous serial input, oversamples it sixteen times per bit, and assembles characters according to a configurable word length and parity mode. Each finished character is stored in a 16-entry receive queue together with three error tags: parity, framing and break. Software-facing logic upstream reads the head of the queue through `rd_data` and pops it with `rd_pop`.

The error flags describe the character currently at the head of the queue, not the one most recently received. A flag is raised when a tagged character becomes the head entry, and it stays raised until a status-read strobe. Overrun protects the stored characters by dropping the new arrival. A summary flag reports whether any errored character is still waiting in the queue. A fill level and a trigger-threshold comparison are provided for interrupt logic elsewhere.

Top module: `uart_rx_tag`

## Requirements
- R1: `data_ready` is 1 exactly while the queue holds at least one character. `fill_level` gives the stored count, saturated at 15, so it reads 0 when empty and 15 with 15 or 16 entries.
- R2: Characters are received LSB first after a start bit. `word_len` selects the data bits: 00=5, 01=6, 10=7, 11=8. Bits above the word length read 0 in `rd_data`, which always shows the head entry.
- R3: When `par_en`=1, a parity bit follows the data bits. `par_mode` selects how it is checked: 00 odd, 01 even, 10 always 1, 11 always 0. A mismatch tags the character with a parity error.
- R4: A stop bit sampled as 0 tags the character with a framing error. That stop bit is then taken as the start bit of the next character, whose data bits follow immediately.
- R5: If the line stays low for a whole frame (start, data, parity and stop all 0), one character of value 0 is stored with both the break and framing tags. The receiver then waits for the line to go high before looking for another start bit.
- R6: If a character completes while the queue holds 16 entries, `overrun` is set. The new character is discarded and the stored entries are unchanged.
- R7: `parity_err`, `framing_err` and `break_det` are raised one cycle after a character carrying the matching tag becomes the head entry, not when it is received.
- R8: A `stat_rd` pulse clears `overrun`, `parity_err`, `framing_err` and `break_det`. If a set event falls in the same cycle, the set wins.
- R9: `fifo_err` is raised when an errored character becomes the head. A `stat_rd` clears it only if no errored character remains in the queue.
- R10: `trig_hit` is 1 when the count reaches the threshold chosen by `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R11: A one-cycle `fifo_clr` pulse empties the queue, resets its pointers and clears `fifo_err`.
- R12: A low on the line that is no longer low at the mid-point of the start bit (8 ticks in) is ignored, and no character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input line |
| word_len | input | 2 | Data bits per character (00=5 … 11=8) |
| par_en | input | 1 | Parity bit present |
| par_mode | input | 2 | Parity check mode |
| trig_sel | input | 2 | Trigger threshold select |
| rd_pop | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status-read strobe, clears read-sensitive flags |
| fifo_clr | input | 1 | Empty the receive queue |
| rd_data | output | 8 | Head entry data |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Character lost because the queue was full |
| parity_err | output | 1 | Head character had a parity error |
| framing_err | output | 1 | Head character had a framing error |
| break_det | output | 1 | Head character was a break |
| fifo_err | output | 1 | An errored character is in the queue |
| fill_level | output | 4 | Saturated entry count |
| trig_hit | output | 1 | Count at or above the threshold |

## Verification
Two events can land in the same cycle: a flag being set because a new head is presented, and the flag being cleared by a status read. The bench provokes this by popping a clean head that sits in front of a parity-errored character, then pulsing `stat_rd` in the cycle the new head's tag is registered. It expects `parity_err` and `fifo_err` to stay set, and expects a later status read on its own to clear them. It also checks that `fifo_err` survives a status read while the errored entry is still stored.

// File: rtl/uart_rx_tag.sv
module uart_rx_tag #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic [1:0] par_mode,
  input  logic [1:0] trig_sel,
  input  logic       rd_pop,
  input  logic       stat_rd,
  input  logic       fifo_clr,
  output logic [7:0] rd_data,
  output logic       data_ready,
  output logic       overrun,
  output logic       parity_err,
  output logic       framing_err,
  output logic       break_det,
  output logic       fifo_err,
  output logic [3:0] fill_level,
  output logic       trig_hit
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = 11;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t        st;
  logic [1:0] sync;
  logic [3:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] shr;
  logic       pbit;

  wire        rx       = sync[1];
  wire  [2:0] last_bit = 3'd4 + {1'b0, word_len};
  wire        mid      = os_tick && tcnt == 4'd15;
  wire        dpar     = ^shr;

  logic par_bad;
  always_comb
    case (par_mode)
      2'b00:   par_bad = ~(dpar ^ pbit);
      2'b01:   par_bad = dpar ^ pbit;
      2'b10:   par_bad = ~pbit;
      default: par_bad = pbit;
    endcase

  wire       char_done = (st == S_STOP) && mid;
  wire       stop_bad  = ~rx;
  wire       is_brk    = stop_bad && shr == 8'd0 && !(par_en && pbit);
  wire [2:0] tags      = {is_brk, stop_bad, par_en && par_bad && !is_brk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; bidx <= '0; shr <= '0; pbit <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!rx) begin st <= S_START; tcnt <= '0; end
        S_START: if (os_tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd7) begin
            tcnt <= '0;
            if (!rx) begin st <= S_DATA; bidx <= '0; shr <= '0; end
            else st <= S_IDLE;
          end
        end
        S_DATA: if (os_tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            shr[bidx] <= rx;
            bidx <= bidx + 3'd1;
            if (bidx == last_bit) st <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          if (os_tick) tcnt <= tcnt + 4'd1;
          if (mid) begin pbit <= rx; st <= S_STOP; end
        end
        S_STOP: begin
          if (os_tick) tcnt <= tcnt + 4'd1;
          if (mid) begin
            if (rx)          st <= S_IDLE;
            else if (is_brk) st <= S_HOLD;
            else begin st <= S_DATA; bidx <= '0; shr <= '0; end
          end
        end
        default: if (rx) st <= S_IDLE;
      endcase
    end

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, ecnt;
  logic          fresh;

  wire          full     = cnt == (AW+1)'(DEPTH);
  wire          empty    = cnt == '0;
  wire          push     = char_done && !full;
  wire          pop      = rd_pop && !empty;
  wire [EW-1:0] head     = mem[rp];
  wire          head_err = |head[10:8];

  always_ff @(posedge clk)
    if (push) mem[wp] <= {tags, shr};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; ecnt <= '0; fresh <= 1'b0;
    end else if (fifo_clr) begin
      wp <= '0; rp <= '0; cnt <= '0; ecnt <= '0; fresh <= 1'b0;
    end else begin
      wp    <= wp + AW'(push);
      rp    <= rp + AW'(pop);
      cnt   <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      ecnt  <= ecnt + (AW+1)'(push && |tags) - (AW+1)'(pop && head_err);
      fresh <= (push && (empty || (cnt == (AW+1)'(1) && pop))) || (pop && cnt > (AW+1)'(1));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      overrun <= 1'b0; parity_err <= 1'b0; framing_err <= 1'b0;
      break_det <= 1'b0; fifo_err <= 1'b0;
    end else begin
      overrun     <= (char_done && full) || (overrun && !stat_rd);
      parity_err  <= (fresh && head[8])  || (parity_err && !stat_rd);
      framing_err <= (fresh && head[9])  || (framing_err && !stat_rd);
      break_det   <= (fresh && head[10]) || (break_det && !stat_rd);
      fifo_err    <= !fifo_clr && ((fresh && head_err) || (fifo_err && !(stat_rd && ecnt == '0)));
    end

  logic [AW:0] thr;
  always_comb
    case (trig_sel)
      2'b00:   thr = (AW+1)'(1);
      2'b01:   thr = (AW+1)'(4);
      2'b10:   thr = (AW+1)'(8);
      default: thr = (AW+1)'(14);
    endcase

  assign rd_data    = head[7:0];
  assign data_ready = !empty;
  assign fill_level = (cnt > (AW+1)'(15)) ? 4'd15 : cnt[3:0];
  assign trig_hit   = cnt >= thr;
endmodule

// File: rtl/uart_rx_tag_chk.sv
module uart_rx_tag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic       fifo_clr,
  input logic       rd_pop,
  input logic       data_ready,
  input logic       overrun,
  input logic [3:0] fill_level,
  input logic       trig_hit,
  input logic       char_done,
  input logic       full
);
  // R11
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (!data_ready && fill_level == 4'd0));

  // R6
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(char_done && full));

  // R6
  ovr_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && full && !rd_pop && !fifo_clr) |=> fill_level == $past(fill_level));

  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(char_done && full)) |=> !overrun);

  // R10
  trig_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_ready);

  // R1
  empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> fill_level == 4'd0);
endmodule

bind uart_rx_tag uart_rx_tag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .fifo_clr(fifo_clr),
  .rd_pop(rd_pop), .data_ready(data_ready), .overrun(overrun),
  .fill_level(fill_level), .trig_hit(trig_hit), .char_done(char_done), .full(full)
);

// File: tb/sim_uart_rx_tag.sv
`timescale 1ns/1ps
module sim_uart_rx_tag;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, os_tick = 1'b1, rxd = 1'b1;
  logic [1:0] word_len = 2'b11, par_mode = 2'b00, trig_sel = 2'b00;
  logic       par_en = 1'b0, rd_pop = 1'b0, stat_rd = 1'b0, fifo_clr = 1'b0;
  logic [7:0] rd_data;
  logic       data_ready, overrun, parity_err, framing_err, break_det, fifo_err, trig_hit;
  logic [3:0] fill_level;

  uart_rx_tag u0 (.*);

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;

  // fields: [15:14] word_len, [13] par_en, [12:11] par_mode, [10] corrupt parity, [7:0] data
  localparam logic [15:0] VEC [9] = '{
    {2'b11, 1'b0, 2'b00, 1'b0, 2'b00, 8'hA5},
    {2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 8'hFF},
    {2'b01, 1'b1, 2'b00, 1'b0, 2'b00, 8'h2C},
    {2'b10, 1'b1, 2'b01, 1'b0, 2'b00, 8'h5A},
    {2'b11, 1'b1, 2'b01, 1'b1, 2'b00, 8'h81},
    {2'b11, 1'b1, 2'b00, 1'b1, 2'b00, 8'h3C},
    {2'b10, 1'b1, 2'b10, 1'b0, 2'b00, 8'h11},
    {2'b00, 1'b1, 2'b11, 1'b1, 2'b00, 8'h0A},
    {2'b11, 1'b1, 2'b10, 1'b1, 2'b00, 8'hF0}
  };

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitout(input logic v);
    rxd = v;
    idle(16);
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic [1:0] m);
    logic p;
    p = ^(d & 8'((1 << nb) - 1));
    case (m)
      2'b00:   return ~p;
      2'b01:   return p;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(input logic [7:0] d, input logic bad_par, input logic stop_v);
    int nb;
    nb = 5 + int'(word_len);
    bitout(1'b0);
    for (int i = 0; i < nb; i++) bitout(d[i]);
    if (par_en) bitout(par_of(d, nb, par_mode) ^ bad_par);
    bitout(stop_v);
    rxd = 1'b1;
    idle(20);
  endtask

  task automatic do_pop;  rd_pop = 1'b1;   idle(1); rd_pop = 1'b0;   endtask
  task automatic do_stat; stat_rd = 1'b1;  idle(1); stat_rd = 1'b0;  endtask
  task automatic do_clr;  fifo_clr = 1'b1; idle(1); fifo_clr = 1'b0; endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 reset data_ready", data_ready, 0);
    chk("R1 reset fill_level", fill_level, 0);
    chk("R6 reset overrun", overrun, 0);
    chk("R9 reset fifo_err", fifo_err, 0);

    for (int k = 0; k < 9; k++) begin
      logic [7:0] m;
      word_len = VEC[k][15:14];
      par_en   = VEC[k][13];
      par_mode = VEC[k][12:11];
      m = 8'((1 << (5 + int'(word_len))) - 1);
      send(VEC[k][7:0], VEC[k][10], 1'b1);
      chk("R2 data", rd_data, VEC[k][7:0] & m);
      chk("R3 parity_err", parity_err, VEC[k][10]);
      chk("R1 data_ready", data_ready, 1);
      do_stat(); do_pop(); idle(3);
      chk("R8 parity cleared", parity_err, 0);
      chk("R1 empty after pop", data_ready, 0);
    end

    // R12 glitch
    word_len = 2'b11; par_en = 1'b0;
    rxd = 1'b0; idle(6); rxd = 1'b1; idle(300);
    chk("R12 glitch ignored", data_ready, 0);

    // R4 framing error and resync on the bad stop bit
    bitout(1'b0);
    for (int i = 0; i < 8; i++) bitout(8'h55 >> i);
    bitout(1'b0);
    for (int i = 0; i < 8; i++) bitout(8'hA3 >> i);
    bitout(1'b1);
    idle(30);
    chk("R4 two chars", fill_level, 2);
    chk("R4 head data", rd_data, 8'h55);
    chk("R4 framing_err", framing_err, 1);
    do_stat(); do_pop(); idle(3);
    chk("R4 resync data", rd_data, 8'hA3);
    chk("R4 framing cleared, next clean", framing_err, 0);
    do_pop(); idle(2);

    // R5 break
    rxd = 1'b0; idle(600); rxd = 1'b1; idle(40);
    chk("R5 single char", fill_level, 1);
    chk("R5 break data", rd_data, 0);
    chk("R5 break_det", break_det, 1);
    chk("R5 framing with break", framing_err, 1);
    chk("R5 no parity", parity_err, 0);
    do_pop(); do_stat(); idle(3);
    chk("R8 break cleared", break_det, 0);
    chk("R9 fifo_err cleared", fifo_err, 0);

    // R7 R8 R9 head tracking and same-cycle set/clear
    par_en = 1'b1; par_mode = 2'b01;
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b1, 1'b1);
    chk("R7 clean head no flag", parity_err, 0);
    chk("R9 errored not at head", fifo_err, 0);
    do_pop();
    do_stat();
    chk("R8 set wins over read", parity_err, 1);
    chk("R9 set on head", fifo_err, 1);
    do_stat(); idle(1);
    chk("R8 read clears", parity_err, 0);
    chk("R9 kept while errored stored", fifo_err, 1);
    do_pop(); do_stat(); idle(1);
    chk("R9 cleared when none left", fifo_err, 0);

    // R6 R1 R10 fill, trigger, overrun
    par_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      send(8'(i * 3 + 1), 1'b0, 1'b1);
      if (i == 0)  begin trig_sel = 2'b00; idle(1); chk("R10 thr1", trig_hit, 1); end
      if (i == 2)  begin trig_sel = 2'b01; idle(1); chk("R10 thr4 below", trig_hit, 0); end
      if (i == 3)  begin idle(1); chk("R10 thr4 at", trig_hit, 1); end
      if (i == 7)  begin trig_sel = 2'b10; idle(1); chk("R10 thr8", trig_hit, 1);
                         trig_sel = 2'b11; idle(1); chk("R10 thr14 below", trig_hit, 0); end
      if (i == 13) begin idle(1); chk("R10 thr14 at", trig_hit, 1); end
    end
    chk("R1 fill saturates", fill_level, 15);
    chk("R6 no overrun yet", overrun, 0);
    send(8'hEE, 1'b0, 1'b1);
    chk("R6 overrun", overrun, 1);
    chk("R6 level kept", fill_level, 15);
    for (int i = 0; i < 16; i++) begin
      chk("R6 contents kept", rd_data, (i * 3 + 1));
      do_pop();
    end
    idle(1);
    chk("R6 new char dropped", data_ready, 0);
    do_stat(); idle(1);
    chk("R8 overrun cleared", overrun, 0);

    // R11 queue reset
    par_en = 1'b1;
    send(8'h33, 1'b1, 1'b1);
    send(8'h44, 1'b0, 1'b1);
    chk("R9 errored head", fifo_err, 1);
    do_clr(); idle(2);
    chk("R11 empty", data_ready, 0);
    chk("R11 level", fill_level, 0);
    chk("R11 fifo_err", fifo_err, 0);
    send(8'h5C, 1'b0, 1'b1);
    chk("R11 receive after reset", rd_data, 8'h5C);
    chk("R11 single entry", fill_level, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule